// File: doc/BRIEF.md
# Two-Stage Bit-Rate Tick Generator

This block turns the system clock into a one-clock enable pulse at a programmed bit rate for a serial port. The clock first passes through a coarse prescaler whose factor is picked by a 5-bit code. The prescaler pulses then drive an 11-bit programmable divider, which fires the output tick once every divisor-plus-one prescaler pulses.

Software programs the rate through two byte-wide write registers. The control register carries the prescaler code in its upper five bits and divisor bits 10 to 8 in its lower three bits. The second register carries divisor bits 7 to 0. The control register clears on reset, so the generator is idle until a code is written. The low divisor byte has no reset and keeps its value across a reset. Any write to either register restarts both counting stages. The new rate therefore takes effect cleanly from the write onward.

The prescaler supports half-step factors. Code n gives an average prescaler period of (n+1)/2 clocks. For an even code, the prescaler alternates between a long period and a short period.

Top module: `bitrate_gen`

## Requirements
- R1: With `wr_sel_i`=0, a write loads bits 7:3 of `wr_data_i` as the prescaler code and bits 2:0 as divisor bits 10:8. With `wr_sel_i`=1, a write loads `wr_data_i` as divisor bits 7:0. The effective divisor is the full 11-bit value d.
- R2: Reset clears the prescaler code and the upper divisor bits. After reset, `tick_o` stays low until a nonzero code is written.
- R3: Reset leaves divisor bits 7:0 unchanged. After reset, a write of the control register alone produces the rate that uses the low byte programmed before reset.
- R4: With prescaler code 0, `tick_o` never goes high.
- R5: For an odd code n, every prescaler period is (n+1)/2 clocks.
- R6: For an even code n, prescaler periods alternate between n/2+1 and n/2 clocks. The longer period comes first after a write.
- R7: `tick_o` fires on every (d+1)-th prescaler pulse after a write.
- R8: When the total period exceeds one clock, `tick_o` is high for exactly one clock per period.
- R9: A write to either register restarts both stages. `tick_o` is low in the cycle after the write edge. Counting clock edges from the write edge, with A=(n+2)/2 and B=(n+1)/2 (integer division), `tick_o` is high right after edge ceil(j/2)*A + floor(j/2)*B for every j that is a multiple of d+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 selects the control register (code and divisor bits 10:8), 1 selects divisor bits 7:0 |
| wr_data_i | input | 8 | Write data byte |
| tick_o | output | 1 | One-clock bit-rate enable |

## Verification
Every result is timed from the clock edge that captures the last register write. `tick_o` is low at the first falling edge after that write edge. The k-th tick is due right after edge T, where T is the clock count of the first k(d+1) prescaler periods under the long/short alternation. The bench computes T arithmetically and samples `tick_o` at the falling edge after every clock edge of the observation window. Each sample is compared with a membership test against the computed set of tick edges, so both early and late pulses, and pulses that are too wide, are caught. Idle cases, namely code 0 and the state just after reset, are watched for a fixed number of cycles.

// File: rtl/brg_pkg.sv
package brg_pkg;

   // Register select encoding on the write port
   typedef enum logic {
      SEL_CTRL  = 1'b0,   // prescaler code + divisor high bits
      SEL_DIVLO = 1'b1    // divisor low byte
   } brg_sel_e;

endpackage

// File: rtl/brg_regs.sv
module brg_regs
   import brg_pkg::*;
#(
   parameter int REG_W = 8,
   parameter int PSC_W = 5,
   parameter int DIV_W = 11
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic             wr_sel_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [PSC_W-1:0] code_o,
   output logic [DIV_W-1:0] div_o,
   output logic             reload_o
);

   localparam int HI_W = DIV_W - REG_W;

   if (HI_W < 1)
      $error("brg_regs: DIV_W must exceed REG_W");
   if (PSC_W + HI_W != REG_W)
      $error("brg_regs: code and divisor high bits must fill one register");

   logic [PSC_W-1:0] code_q;
   logic [HI_W-1:0]  hi_q;
   logic [REG_W-1:0] lo_q;
   logic             wr_ctrl, wr_lo;

   assign wr_ctrl = wr_en_i && (brg_sel_e'(wr_sel_i) == SEL_CTRL);
   assign wr_lo   = wr_en_i && (brg_sel_e'(wr_sel_i) == SEL_DIVLO);

   // Control register: cleared by reset (R2)
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_q <= '0;
         hi_q   <= '0;
      end else if (wr_ctrl) begin
         code_q <= wr_data_i[REG_W-1 -: PSC_W];
         hi_q   <= wr_data_i[HI_W-1:0];
      end
   end

   // Low divisor byte: deliberately without reset (R3)
   always_ff @(posedge clk_i) begin
      if (wr_lo)
         lo_q <= wr_data_i;
   end

   assign code_o   = code_q;
   assign div_o    = {hi_q, lo_q};
   assign reload_o = wr_en_i;

   p_ctrl_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_ctrl) |=> $stable(code_q) && $stable(hi_q));

endmodule

// File: rtl/brg_prescale.sv
module brg_prescale #(
   parameter int PSC_W     = 5,
   parameter bit HALF_STEP = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [PSC_W-1:0] code_i,
   output logic             pulse_o
);

   localparam int LEN_W = PSC_W + 1;

   if (PSC_W < 2)
      $error("brg_prescale: PSC_W too small");

   logic             run;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_cur;
   logic             hit;

   assign run     = (code_i != '0);
   assign hit     = run && (cnt_q == len_cur - LEN_W'(1));
   assign pulse_o = hit;

   if (HALF_STEP) begin : g_half
      logic             phase_q;
      logic [LEN_W-1:0] len_long, len_short;

      // Average factor (n+1)/2: long then short period for even codes
      assign len_long  = (LEN_W'(code_i) + LEN_W'(2)) >> 1;
      assign len_short = (LEN_W'(code_i) + LEN_W'(1)) >> 1;
      assign len_cur   = phase_q ? len_short : len_long;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
         end else if (load_i || !run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
         end else if (hit) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
         end else begin
            cnt_q   <= cnt_q + LEN_W'(1);
         end
      end

      p_phase_flip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (hit && !load_i) |=> (phase_q != $past(phase_q)));
      p_phase_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         load_i |=> !phase_q);
   end else begin : g_whole
      assign len_cur = LEN_W'(code_i);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            cnt_q <= '0;
         else if (load_i || !run || hit)
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + LEN_W'(1);
      end
   end

   p_cnt_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && !load_i) |-> (cnt_q < len_cur));
   p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (cnt_q == '0));

endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
   parameter int DIV_W = 11
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [DIV_W-1:0] limit_i,
   output logic             tick_o
);

   if (DIV_W < 1)
      $error("brg_divider: DIV_W must be positive");

   logic [DIV_W-1:0] cnt_q;
   logic             tick_q;
   logic             wrap;

   assign wrap = (cnt_q == limit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (load_i) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= step_i && wrap;
         if (step_i)
            cnt_q <= wrap ? '0 : cnt_q + DIV_W'(1);
      end
   end

   assign tick_o = tick_q;

   p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i |-> (cnt_q <= limit_i));
   p_one_wide_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_q && limit_i != '0) |=> !tick_q);

endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen #(
   parameter int REG_W     = 8,
   parameter int PSC_W     = 5,
   parameter int DIV_W     = 11,
   parameter bit HALF_STEP = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic             wr_sel_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic             tick_o
);

   logic [PSC_W-1:0] code;
   logic [DIV_W-1:0] div;
   logic             reload;
   logic             psc_pulse;

   brg_regs #(
      .REG_W (REG_W),
      .PSC_W (PSC_W),
      .DIV_W (DIV_W)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (wr_sel_i),
      .wr_data_i (wr_data_i),
      .code_o    (code),
      .div_o     (div),
      .reload_o  (reload)
   );

   brg_prescale #(
      .PSC_W     (PSC_W),
      .HALF_STEP (HALF_STEP)
   ) u_psc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (reload),
      .code_i  (code),
      .pulse_o (psc_pulse)
   );

   brg_divider #(
      .DIV_W (DIV_W)
   ) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (reload),
      .step_i  (psc_pulse),
      .limit_i (div),
      .tick_o  (tick_o)
   );

   p_off_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code == '0) |=> !tick_o);
   p_write_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> !tick_o);
   p_tick_needs_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!psc_pulse) |=> !tick_o);

endmodule

// File: tb/bitrate_gen_test.sv
`timescale 1ns/1ps
module bitrate_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic       tick;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bitrate_gen uut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .wr_sel_i  (wr_sel),
      .wr_data_i (wr_data),
      .tick_o    (tick)
   );

   // Clock edges from the write edge to prescaler pulse j
   function automatic int cum(input int j, input int n);
      int a = (n + 2) / 2;
      int b = (n + 1) / 2;
      return ((j + 1) / 2) * a + (j / 2) * b;
   endfunction

   function automatic bit is_tick(input int k, input int n, input int d);
      if (n == 0) return 1'b0;
      for (int m = 1; m <= k; m++) begin
         int t = cum(m * (d + 1), n);
         if (t == k) return 1'b1;
         if (t > k)  return 1'b0;
      end
      return 1'b0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Returns at the falling edge right after the write edge
   task automatic write_reg(input bit sel, input logic [7:0] data);
      @(negedge clk);
      wr_en = 1'b1;
      wr_sel = sel;
      wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic quiet(input int cycles, input string req);
      int seen = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (tick !== 1'b0) seen++;
      end
      check(seen == 0, req, seen, 0);
   endtask

   task automatic observe(input int n, input int d, input string req);
      int miss = 0;
      int first_k = -1;
      int first_act = 0;
      int len;
      check(tick === 1'b0, "R9", int'(tick), 0);
      len = (n == 0) ? 100 : cum(3 * (d + 1), n) + 2;
      for (int k = 1; k <= len; k++) begin
         bit exp;
         @(negedge clk);
         exp = is_tick(k, n, d);
         if (tick !== exp) begin
            miss++;
            if (first_k < 0) begin
               first_k = k;
               first_act = int'(tick);
            end
         end
      end
      if (miss != 0)
         $display("   code=%0d div=%0d first mismatch at edge %0d", n, d, first_k);
      check(miss == 0, req, first_act, (first_k < 0) ? 0 : int'(is_tick(first_k, n, d)));
   endtask

   task automatic run_cfg(input int n, input int d, input string req);
      logic [7:0] ctrl;
      write_reg(1'b1, d[7:0]);
      ctrl = {n[4:0], d[10:8]};
      write_reg(1'b0, ctrl);
      observe(n, d, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: idle out of reset
      quiet(40, "R2");

      // R5 / R6 / R4 / R7: sweep every code over small divisors
      for (int n = 0; n < 32; n++) begin
         int dl[4] = '{0, 1, 3, 6};
         foreach (dl[i]) begin
            if (n == 0)           run_cfg(n, dl[i], "R4");
            else if (n % 2 == 1)  run_cfg(n, dl[i], "R5");
            else                  run_cfg(n, dl[i], "R6");
         end
      end
      run_cfg(1, 0, "R7");
      run_cfg(7, 12, "R7");

      // R1: divisor high bits taken from the control register
      run_cfg(3, 'h2A5, "R1");
      run_cfg(2, 'h7FF, "R1");

      // R8: single-cycle width over a multi-clock period
      run_cfg(6, 2, "R8");

      // R9: rewrite partway through a period
      run_cfg(4, 5, "R9");
      write_reg(1'b1, 8'd5);
      repeat (7) @(negedge clk);
      write_reg(1'b0, {5'd4, 3'd0});
      observe(4, 5, "R9");

      // R2 / R3: reset clears control but keeps the low divisor byte
      run_cfg(5, 9, "R3");
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      quiet(60, "R2");
      write_reg(1'b0, {5'd3, 3'd0});
      observe(3, 9, "R3");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule